// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block supervises a small processor core. It counts ticks from one of two sources: a free-running oscillator tick, delivered as a one-cycle strobe already in the block's clock domain, or an instruction clock that the block makes itself by dividing its own clock by four. A prescaler with a selectable power-of-two ratio feeds a wide divider. When the divider wraps, the block raises a reset toward the core.

The kind of reset depends on the core's state. If the core is running, the block emits a chip reset pulse and sets a sticky time-out flag. If the core is halted, it emits a warm reset pulse instead, which only rewinds the program counter and stack pointer. The flag is left as it was.

Software keeps the watchdog quiet by issuing clear strobes. A mode input picks one of two schemes. In the first, one clear instruction is enough. In the second, two different clear instructions must both have run, in either order. Entering halt and the external active-low reset also restart the count. A configuration input can switch the whole watchdog off.

Top module: `wdog_pair_clr`

## Requirements
- R1: With `cfg_src_osc`=1 each cycle with `osc_tick` high is one source tick. With `cfg_src_osc`=0 one source tick occurs every fourth clock cycle, from a free-running phase counter.
- R2: After a clear taken at clock edge E0, the divider wraps on the edge that carries source-side prescaled tick number 2^DIV_W, which is source tick number 2^DIV_W * 2^`cfg_pre_sel` (`cfg_pre_sel` from 0 to 7). The reset pulse is visible in the cycle after that edge.
- R3: A wrap while `halted`=0 at the wrap edge gives a one-cycle `chip_rst` pulse and sets `to_flag` in that same cycle. `warm_rst` stays 0.
- R4: A wrap while `halted`=1 at the wrap edge gives a one-cycle `warm_rst` pulse. `chip_rst` stays 0 and `to_flag` keeps its value.
- R5: With `cfg_src_osc`=0 and `halted`=1 no source ticks occur, so the count holds and no reset is raised.
- R6: With `cfg_enable`=0 no reset pulse is ever raised, and clear strobes have no effect; in particular `to_flag` stays set.
- R7: `rst_n`=0 clears the counters, pending clear state, both pulses and `to_flag`.
- R8: A `halt_enter` strobe restarts the count and the prescaler, and discards a half-completed clear pair.
- R9: With `cfg_dual_clr`=0 a `clr_single` strobe clears the watchdog; `clr_first` and `clr_second` are ignored.
- R10: With `cfg_dual_clr`=1 the watchdog clears on the cycle in which both `clr_first` and `clr_second` have been seen since the last clear. They may come in either order or in the same cycle. Repeating one of them does not complete the pair. `clr_single` is ignored.
- R11: A successful clear instruction (R9 or R10) clears `to_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the base of the instruction clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| cfg_enable | input | 1 | 1 = watchdog active, 0 = switched off |
| cfg_src_osc | input | 1 | 1 = oscillator tick source, 0 = clock divided by four |
| cfg_dual_clr | input | 1 | 1 = paired clear instructions, 0 = single clear instruction |
| cfg_pre_sel | input | 3 | Prescaler ratio exponent, divide by 2^value |
| osc_tick | input | 1 | One-cycle tick from the free-running oscillator |
| halted | input | 1 | Core is in halt |
| halt_enter | input | 1 | One-cycle strobe when the core enters halt |
| clr_single | input | 1 | Single clear instruction strobe |
| clr_first | input | 1 | First paired clear instruction strobe |
| clr_second | input | 1 | Second paired clear instruction strobe |
| chip_rst | output | 1 | One-cycle full chip reset request |
| warm_rst | output | 1 | One-cycle warm reset request (program counter, stack pointer) |
| to_flag | output | 1 | Sticky time-out status |

## Verification
The bench sweeps every prescaler ratio on both sources and measures the exact cycle of the wrap. A wrong prescaler mask or a wrong clock divider would move the pulse by a factor of two or by a few cycles. The pair tracker is driven with reversed order, same-cycle pairs, repeated halves and a halt entry between the halves. A tracker that keeps stale halves, or that lets one half count twice, would clear early, and the pulse would come late by a measurable number of cycles. The bench also checks the halted cases and the disabled case. Picking the wrong reset kind would show as a warm pulse where a chip pulse is due, or the reverse. Counting during halt on the instruction clock would show as a pulse that should not occur. A disabled watchdog that still acted on a clear would drop `to_flag`.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Ratio between the block clock and the instruction clock.
  localparam int INSTR_DIV = 4;

  // Width of the prescaler ratio field.
  localparam int SEL_W = 3;

  // Kind of reset raised by a wrap.
  typedef enum logic [1:0] {
    RST_NONE = 2'b00,
    RST_CHIP = 2'b01,
    RST_WARM = 2'b10
  } rst_kind_t;

  function automatic rst_kind_t pick_reset(input logic wrap, input logic core_halted);
    if (!wrap)           return RST_NONE;
    else if (core_halted) return RST_WARM;
    else                 return RST_CHIP;
  endfunction

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src #(
  parameter int DIV = wdog_pkg::INSTR_DIV
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_osc,
  input  logic osc_tick,
  input  logic halted,
  output logic src_tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase;
  logic            instr_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else                       phase <= phase + PH_W'(1);
  end

  assign instr_tick = (phase == PH_LAST);

  // The instruction clock stops while the core is halted.
  assign src_tick = src_osc ? osc_tick : (instr_tick & ~halted);
endmodule

// File: rtl/wdog_clear_ctl.sv
module wdog_clear_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic dual,
  input  logic clr_single,
  input  logic clr_first,
  input  logic clr_second,
  input  logic halt_enter,
  output logic clr_ok,
  output logic wd_clear
);
  logic seen_a;
  logic seen_b;

  always_comb begin
    if (!enable)   clr_ok = 1'b0;
    else if (dual) clr_ok = (seen_a | clr_first) & (seen_b | clr_second);
    else           clr_ok = clr_single;
  end

  // Held in clear while disabled so nothing runs.
  assign wd_clear = clr_ok | halt_enter | ~enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else if (wd_clear || !dual) begin
      seen_a <= 1'b0;
      seen_b <= 1'b0;
    end else begin
      seen_a <= seen_a | clr_first;
      seen_b <= seen_b | clr_second;
    end
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W = wdog_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic             pre_tick
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] cnt;
  logic [PRE_W-1:0] mask;

  // Low 'sel' bits of the mask are set.
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign mask[g] = (sel > SEL_W'(g));
  end

  assign pre_tick = tick & ((cnt & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + PRE_W'(1);
  end
endmodule

// File: rtl/wdog_divider.sv
module wdog_divider #(
  parameter int DIV_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic step,
  output logic wrap
);
  logic [DIV_W-1:0] cnt;

  // A clear on the same edge wins over a wrap.
  assign wrap = step & (&cnt) & ~clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else if (step)  cnt <= cnt + DIV_W'(1);
  end
endmodule

// File: rtl/wdog_pair_clr.sv
module wdog_pair_clr #(
  parameter int DIV_W = 16,
  parameter int SEL_W = wdog_pkg::SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_enable,
  input  logic             cfg_src_osc,
  input  logic             cfg_dual_clr,
  input  logic [SEL_W-1:0] cfg_pre_sel,
  input  logic             osc_tick,
  input  logic             halted,
  input  logic             halt_enter,
  input  logic             clr_single,
  input  logic             clr_first,
  input  logic             clr_second,
  output logic             chip_rst,
  output logic             warm_rst,
  output logic             to_flag
);
  import wdog_pkg::*;

  logic      src_tick;
  logic      pre_tick;
  logic      clr_ok;
  logic      wd_clear;
  logic      wrap;
  rst_kind_t kind;

  wdog_tick_src #(.DIV(INSTR_DIV)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_osc  (cfg_src_osc),
    .osc_tick (osc_tick),
    .halted   (halted),
    .src_tick (src_tick)
  );

  wdog_clear_ctl u_clr (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_enable),
    .dual       (cfg_dual_clr),
    .clr_single (clr_single),
    .clr_first  (clr_first),
    .clr_second (clr_second),
    .halt_enter (halt_enter),
    .clr_ok     (clr_ok),
    .wd_clear   (wd_clear)
  );

  wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (wd_clear),
    .tick     (src_tick),
    .sel      (cfg_pre_sel),
    .pre_tick (pre_tick)
  );

  wdog_divider #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (wd_clear),
    .step  (pre_tick),
    .wrap  (wrap)
  );

  assign kind = pick_reset(wrap, halted);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_rst <= 1'b0;
      warm_rst <= 1'b0;
      to_flag  <= 1'b0;
    end else begin
      chip_rst <= (kind == RST_CHIP);
      warm_rst <= (kind == RST_WARM);
      if (clr_ok)                to_flag <= 1'b0;
      else if (kind == RST_CHIP) to_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_pair_clr_chk.sv
module wdog_pair_clr_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_src_osc,
  input logic halted,
  input logic chip_rst,
  input logic warm_rst,
  input logic to_flag
);
  // R3
  chip_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  // R3
  chip_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> to_flag && !warm_rst);

  // R3
  chip_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |-> !$past(halted));

  // R4
  warm_only_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |-> $past(halted));

  // R4
  warm_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> !warm_rst);

  // R5
  halt_instr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_src_osc && halted) |-> !chip_rst && !warm_rst);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_enable) |-> !chip_rst && !warm_rst);
endmodule

bind wdog_pair_clr wdog_pair_clr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_enable  (cfg_enable),
  .cfg_src_osc (cfg_src_osc),
  .halted      (halted),
  .chip_rst    (chip_rst),
  .warm_rst    (warm_rst),
  .to_flag     (to_flag)
);

// File: tb/wdog_pair_clr_test.sv
module wdog_pair_clr_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 4;
  localparam int BASE       = 1 << DIV_W;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b1;
  logic       cfg_src_osc = 1'b1;
  logic       cfg_dual_clr = 1'b0;
  logic [2:0] cfg_pre_sel = 3'd0;
  logic       osc_tick = 1'b1;
  logic       halted = 1'b0;
  logic       halt_enter = 1'b0;
  logic       clr_single = 1'b0;
  logic       clr_first = 1'b0;
  logic       clr_second = 1'b0;
  logic       chip_rst;
  logic       warm_rst;
  logic       to_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int t;
  int kind;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wdog_pair_clr #(.DIV_W(DIV_W)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_enable   (cfg_enable),
    .cfg_src_osc  (cfg_src_osc),
    .cfg_dual_clr (cfg_dual_clr),
    .cfg_pre_sel  (cfg_pre_sel),
    .osc_tick     (osc_tick),
    .halted       (halted),
    .halt_enter   (halt_enter),
    .clr_single   (clr_single),
    .clr_first    (clr_first),
    .clr_second   (clr_second),
    .chip_rst     (chip_rst),
    .warm_rst     (warm_rst),
    .to_flag      (to_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Apply strobes for exactly one clock edge.
  task automatic strobe(input logic s, input logic f, input logic sc, input logic h);
    @(negedge clk);
    clr_single = s; clr_first = f; clr_second = sc; halt_enter = h;
    @(negedge clk);
    clr_single = 1'b0; clr_first = 1'b0; clr_second = 1'b0; halt_enter = 1'b0;
  endtask

  // Count edges after the last strobe edge until a reset pulse shows.
  task automatic wait_evt(input int limit, output int tt, output int kk);
    tt = 0; kk = 0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); #1;
      if (chip_rst || warm_rst) begin
        tt = i;
        kk = chip_rst ? 1 : 2;
        break;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 chip after reset", int'(chip_rst), 0);
    chk("R7 warm after reset", int'(warm_rst), 0);
    chk("R7 flag after reset", int'(to_flag), 0);
    rst_n = 1'b1;

    // R1 R2 R3 oscillator source, every ratio
    for (int s = 0; s < 8; s++) begin
      cfg_pre_sel = 3'(s);
      strobe(1, 0, 0, 0);
      wait_evt((BASE << s) + 8, t, kind);
      chk($sformatf("R2 osc period sel=%0d", s), t, BASE << s);
      chk("R3 chip kind", kind, 1);
      chk("R3 flag set", int'(to_flag), 1);
      @(posedge clk); #1;
      chk("R3 single-cycle chip", int'(chip_rst), 0);
    end

    // R1 R2 instruction clock source, every ratio
    cfg_src_osc = 1'b0;
    for (int s = 0; s < 8; s++) begin
      cfg_pre_sel = 3'(s);
      strobe(1, 0, 0, 0);
      wait_evt(4 * (BASE << s) + 8, t, kind);
      chk($sformatf("R1 instr period sel=%0d t=%0d", s, t),
          int'(t >= 4 * (BASE << s) - 3 && t <= 4 * (BASE << s)), 1);
    end

    // R5 halted on instruction clock: no counting
    cfg_pre_sel = 3'd0;
    @(negedge clk); halted = 1'b1;
    strobe(1, 0, 0, 0);
    wait_evt(300, t, kind);
    chk("R5 no pulse while halted on instr clock", t, 0);
    @(negedge clk); halted = 1'b0;
    wait_evt(4 * BASE + 8, t, kind);
    chk("R5 counting resumes", int'(t > 0 && t <= 4 * BASE), 1);

    // R11 successful clear drops the flag
    cfg_src_osc = 1'b1;
    chk("R11 flag before clear", int'(to_flag), 1);
    strobe(1, 0, 0, 0);
    chk("R11 flag after clear", int'(to_flag), 0);

    // R4 halted on oscillator: warm reset only
    @(negedge clk); halted = 1'b1;
    strobe(1, 0, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R4 warm period", t, BASE);
    chk("R4 warm kind", kind, 2);
    chk("R4 flag unchanged", int'(to_flag), 0);
    @(negedge clk); halted = 1'b0;

    // R9 single mode ignores paired instructions
    strobe(1, 0, 0, 0);
    wait_evt(3, t, kind);
    strobe(0, 1, 0, 0);
    wait_evt(3, t, kind);
    strobe(0, 0, 1, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R9 pair ignored in single mode", t + 8, BASE);
    strobe(1, 0, 0, 0);
    wait_evt(3, t, kind);
    strobe(1, 0, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R9 single clear restarts", t, BASE);

    // R10 dual mode
    @(negedge clk); cfg_dual_clr = 1'b1;
    strobe(0, 1, 1, 0);
    wait_evt(3, t, kind);
    strobe(0, 0, 1, 0);
    wait_evt(3, t, kind);
    strobe(0, 1, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R10 reversed order completes", t, BASE);

    strobe(0, 1, 1, 0);
    wait_evt(3, t, kind);
    strobe(0, 1, 0, 0);
    wait_evt(3, t, kind);
    strobe(0, 1, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R10 repeated half does not clear", t + 8, BASE);

    strobe(0, 1, 1, 0);
    wait_evt(3, t, kind);
    strobe(1, 0, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R10 single clear ignored in dual mode", t + 4, BASE);

    // R8 halt entry restarts and drops a pending half
    strobe(0, 1, 1, 0);
    wait_evt(3, t, kind);
    strobe(0, 1, 0, 0);
    wait_evt(3, t, kind);
    strobe(0, 0, 0, 1);
    wait_evt(3, t, kind);
    strobe(0, 0, 1, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R8 halt entry clears count and pair", t + 4, BASE);

    // R6 disabled: clears ignored, no pulses
    chk("R6 flag set before disable", int'(to_flag), 1);
    @(negedge clk); cfg_enable = 1'b0; cfg_dual_clr = 1'b0;
    strobe(1, 0, 0, 0);
    chk("R6 clear ignored while disabled", int'(to_flag), 1);
    wait_evt(200, t, kind);
    chk("R6 no pulse while disabled", t, 0);
    @(negedge clk); cfg_enable = 1'b1;

    // R7 external reset drops the flag
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R7 flag cleared by reset", int'(to_flag), 0);
    chk("R7 chip cleared by reset", int'(chip_rst), 0);
    rst_n = 1'b1;
    strobe(1, 0, 0, 0);
    wait_evt(BASE + 8, t, kind);
    chk("R7 count restarts after reset", t, BASE);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) cycles++;
endmodule